// File: doc/BRIEF.md
# Threshold-Gated Receive Buffer

This block stores samples that arrive from the link side in one small first-in first-out store per channel. It hands them to a consumer on the user side. A channel does not report data as available just because it holds something. Its valid output stays low until the fill level rises above a programmable threshold. Every channel shares that one threshold. The consumer therefore begins to drain only once a comfortable amount of data has built up.

After valid asserts, it stays high until the channel is empty again, so every stored entry can be read out. The channel then re-arms and waits for the next crossing. A write that arrives while a channel is full is discarded, and a sticky per-channel overflow flag records it. One 32-bit configuration word carries the threshold. Its low bits hold the threshold and its upper bits always read back as zero. The output data sits behind a synchronous-read memory with a write-through bypass, so the storage can map onto block RAM.

Top module: `thr_rx_buffer`

## Requirements
- R1: Each channel holds up to 16 entries and returns them in the order they were written. While valid is high, `usr_data` shows the oldest entry.
- R2: The threshold is bits [3:0] of the configuration word. Bits [31:4] are ignored on write and read back as zero.
- R3: After reset, the threshold is 8, every valid output is 0, every overflow flag is 0 and every channel is empty.
- R4: When a channel is not valid, its valid asserts one cycle after its fill count first exceeds the threshold. It stays low while the count is at or below the threshold. With threshold 8, that means 8 entries give no valid and 9 entries do. With threshold 15, valid needs all 16 entries.
- R5: One threshold value governs every channel at once.
- R6: Once asserted, valid stays high until the channel is empty. It then drops and waits for the threshold to be exceeded again.
- R7: A write to a full channel (16 entries) is discarded and sets that channel's overflow flag. The flag then stays at 1 until reset.
- R8: A read request while valid is low removes nothing.
- R9: A write and a read in the same cycle leave the fill count unchanged.
- R10: A new threshold is used from the cycle after the configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 32 | Configuration word to write |
| cfg_rd_data | output | 32 | Configuration word read back |
| lnk_wr_en | input | NUM_CH | Per-channel write request from the link side |
| lnk_wr_data | input | NUM_CH*DATA_W | Per-channel write data; channel c occupies bits [c*DATA_W +: DATA_W] |
| usr_rd_en | input | NUM_CH | Per-channel read request from the consumer |
| usr_valid | output | NUM_CH | Per-channel gated valid |
| usr_data | output | NUM_CH*DATA_W | Per-channel oldest entry |
| ovf_flag | output | NUM_CH | Per-channel sticky overflow flag |

## Verification
The gating is driven with several patterns:
- A fill that stops one entry short of the threshold and then crosses it. This separates a "greater than" comparison from a "greater or equal" comparison and from a plain non-empty test.
- A partial drain, a full drain and a single refill. These show that valid holds down to empty and then re-arms rather than following the threshold on the way down.
- Both channels filled in lockstep under a lowered threshold, which shows that the threshold is shared.
- A fill to sixteen at threshold 15, followed by a seventeenth write. This exercises the full boundary and confirms that the extra entry never reaches the output.
- Back-to-back cycles with a write and a read together, with the data order checked throughout. These expose count errors on combined access and a missing write-through path.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  // width of the software-visible configuration word
  localparam int CFG_W = 32;

  // zero-extend a threshold value into the configuration word
  function automatic logic [CFG_W-1:0] pack_cfg(input logic [7:0] thr, input int thr_w);
    logic [CFG_W-1:0] w;
    w = '0;
    for (int b = 0; b < thr_w; b++) w[b] = thr[b];
    return w;
  endfunction
endpackage

// File: rtl/rxb_cfg.sv
module rxb_cfg
  import rxb_pkg::*;
#(
  parameter int THR_W   = 4,
  parameter int THR_RST = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output logic [THR_W-1:0] thr_o,
  output logic [CFG_W-1:0] rd_data_o
);
  logic [THR_W-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (rst)          thr_q <= THR_W'(THR_RST);
    else if (wr_en_i) thr_q <= wr_data_i[THR_W-1:0];
  end

  assign thr_o     = thr_q;
  assign rd_data_o = {{(CFG_W-THR_W){1'b0}}, thr_q};

  // R3
  reset_thr_chk: assert property (@(posedge clk) rst |=> thr_q == THR_W'(THR_RST));
endmodule

// File: rtl/rxb_mem.sv
module rxb_mem #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] ram [WORDS];

  // single write port, registered read port: block RAM template
  always_ff @(posedge clk) begin
    if (we_i) ram[waddr_i] <= wdata_i;
    rdata_o <= ram[raddr_i];
  end
endmodule

// File: rtl/rxb_channel.sv
module rxb_channel #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [THR_W-1:0] thr_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             rd_en_i,
  output logic             valid_o,
  output logic [DW-1:0]    data_o,
  output logic             ovf_o
);
  // DEPTH is a power of two so pointers wrap on their own
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [AW-1:0] wptr_q, rptr_q, raddr;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          valid_q, valid_nxt, ovf_q;
  logic          full, wr_ok, rd_ok;
  logic          byp_q;
  logic [DW-1:0] byp_data_q, mem_rdata;

  assign full  = (cnt_q == CW'(DEPTH));
  assign wr_ok = wr_en_i && !full;
  assign rd_ok = rd_en_i && valid_q;

  // next head address: advance on a read, else hold
  assign raddr = rd_ok ? rptr_q + AW'(1) : rptr_q;

  always_comb begin
    cnt_nxt = cnt_q;
    case ({wr_ok, rd_ok})
      2'b10:   cnt_nxt = cnt_q + CW'(1);
      2'b01:   cnt_nxt = cnt_q - CW'(1);
      default: cnt_nxt = cnt_q;
    endcase
  end

  // armed: wait for crossing; draining: hold until empty
  always_comb begin
    if (valid_q) valid_nxt = (cnt_nxt != '0);
    else         valid_nxt = (cnt_nxt > CW'(thr_i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (wr_ok) wptr_q <= wptr_q + AW'(1);
      if (rd_ok) rptr_q <= rptr_q + AW'(1);
      cnt_q   <= cnt_nxt;
      valid_q <= valid_nxt;
      if (wr_en_i && full) ovf_q <= 1'b1;
    end
  end

  // write-through path when the new head is written this very cycle
  always_ff @(posedge clk) begin
    if (rst) byp_q <= 1'b0;
    else     byp_q <= wr_ok && (wptr_q == raddr);
    byp_data_q <= wr_data_i;
  end

  rxb_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk     (clk),
    .we_i    (wr_ok),
    .waddr_i (wptr_q),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  assign valid_o = valid_q;
  assign data_o  = byp_q ? byp_data_q : mem_rdata;
  assign ovf_o   = ovf_q;

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt_q <= CW'(DEPTH));
  // R6
  valid_nonempty_chk: assert property (@(posedge clk) disable iff (rst) valid_q |-> cnt_q != '0);
  // R4
  rose_above_thr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> cnt_q > CW'($past(thr_i)));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst) ovf_q |=> ovf_q);
  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en_i && !(rd_en_i && valid_q)) |=> cnt_q == CW'(DEPTH));
  // R8
  idle_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid_q && !wr_en_i) |=> $stable(cnt_q));
  // R9
  wrrd_same_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !full && rd_en_i && valid_q) |=> $stable(cnt_q));
endmodule

// File: rtl/thr_rx_buffer.sv
module thr_rx_buffer
  import rxb_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 16,
  parameter int THR_RST = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_wr_en,
  input  logic [31:0]              cfg_wr_data,
  output logic [31:0]              cfg_rd_data,
  input  logic [NUM_CH-1:0]        lnk_wr_en,
  input  logic [NUM_CH*DATA_W-1:0] lnk_wr_data,
  input  logic [NUM_CH-1:0]        usr_rd_en,
  output logic [NUM_CH-1:0]        usr_valid,
  output logic [NUM_CH*DATA_W-1:0] usr_data,
  output logic [NUM_CH-1:0]        ovf_flag
);
  localparam int THR_W = $clog2(DEPTH);

  logic [THR_W-1:0] thr;

  rxb_cfg #(.THR_W(THR_W), .THR_RST(THR_RST)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (cfg_wr_en),
    .wr_data_i (cfg_wr_data),
    .thr_o     (thr),
    .rd_data_o (cfg_rd_data)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    rxb_channel #(.DW(DATA_W), .DEPTH(DEPTH), .THR_W(THR_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .thr_i     (thr),
      .wr_en_i   (lnk_wr_en[c]),
      .wr_data_i (lnk_wr_data[c*DATA_W +: DATA_W]),
      .rd_en_i   (usr_rd_en[c]),
      .valid_o   (usr_valid[c]),
      .data_o    (usr_data[c*DATA_W +: DATA_W]),
      .ovf_o     (ovf_flag[c])
    );
  end
endmodule

// File: tb/thr_rx_buffer_tb.sv
module thr_rx_buffer_tb;
  localparam int NCH = 2;
  localparam int DW  = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_wr_en = 1'b0;
  logic [31:0]     cfg_wr_data = '0;
  logic [31:0]     cfg_rd_data;
  logic [NCH-1:0]  lnk_wr_en = '0;
  logic [NCH*DW-1:0] lnk_wr_data = '0;
  logic [NCH-1:0]  usr_rd_en = '0;
  logic [NCH-1:0]  usr_valid;
  logic [NCH*DW-1:0] usr_data;
  logic [NCH-1:0]  ovf_flag;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] m0[$];
  logic [DW-1:0] m1[$];

  always #4 clk = ~clk;

  thr_rx_buffer u_dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .lnk_wr_en(lnk_wr_en), .lnk_wr_data(lnk_wr_data),
    .usr_rd_en(usr_rd_en), .usr_valid(usr_valid), .usr_data(usr_data), .ovf_flag(ovf_flag)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model update after the edge
  task automatic cyc(input logic [1:0] we, input logic [1:0] re, input logic [15:0] d0, input logic [15:0] d1);
    logic [1:0] vb;
    vb = usr_valid;
    if (re[0] && vb[0]) chk(usr_data[15:0] == m0[0], "R1 ch0 order", usr_data[15:0], m0[0]);
    if (re[1] && vb[1]) chk(usr_data[31:16] == m1[0], "R1 ch1 order", usr_data[31:16], m1[0]);
    lnk_wr_en = we; usr_rd_en = re; lnk_wr_data = {d1, d0};
    @(negedge clk);
    lnk_wr_en = '0; usr_rd_en = '0;
    if (re[0] && vb[0]) void'(m0.pop_front());
    if (re[1] && vb[1]) void'(m1.pop_front());
    if (we[0] && m0.size() < 16) m0.push_back(d0);
    if (we[1] && m1.size() < 16) m1.push_back(d1);
  endtask

  task automatic cfg_write(input logic [31:0] w);
    cfg_wr_en = 1'b1; cfg_wr_data = w;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic test_reset();
    chk(usr_valid == 2'b00, "R3 valid", usr_valid, 0);
    chk(ovf_flag == 2'b00, "R3 ovf", ovf_flag, 0);
    chk(cfg_rd_data == 32'd8, "R3 threshold", cfg_rd_data, 8);
  endtask

  task automatic test_gate_default();
    for (int i = 0; i < 8; i++) cyc(2'b01, 2'b00, 16'h100 + 16'(i), 0);
    chk(usr_valid[0] == 1'b0, "R4 eight entries", usr_valid[0], 0);
    cyc(2'b01, 2'b00, 16'h108, 0);
    chk(usr_valid[0] == 1'b1, "R4 nine entries", usr_valid[0], 1);
    chk(usr_valid[1] == 1'b0, "R4 other channel", usr_valid[1], 0);
    for (int i = 0; i < 8; i++) cyc(2'b00, 2'b01, 0, 0);
    chk(usr_valid[0] == 1'b1, "R6 holds below threshold", usr_valid[0], 1);
    cyc(2'b00, 2'b01, 0, 0);
    chk(usr_valid[0] == 1'b0, "R6 drops at empty", usr_valid[0], 0);
    cyc(2'b01, 2'b00, 16'h200, 0);
    chk(usr_valid[0] == 1'b0, "R6 re-armed", usr_valid[0], 0);
    cyc(2'b00, 2'b01, 0, 0);
    for (int i = 1; i < 8; i++) cyc(2'b01, 2'b00, 16'h200 + 16'(i), 0);
    chk(usr_valid[0] == 1'b0, "R8 read while low kept entry", usr_valid[0], 0);
    cyc(2'b01, 2'b00, 16'h208, 0);
    chk(usr_valid[0] == 1'b1 && usr_data[15:0] == 16'h200, "R8 head survives",
        {15'd0, usr_valid[0], usr_data[15:0]}, {16'd1, 16'h200});
    for (int i = 0; i < 9; i++) cyc(2'b00, 2'b01, 0, 0);
    chk(usr_valid[0] == 1'b0 && m0.size() == 0, "R6 drained", usr_valid[0], 0);
  endtask

  task automatic test_shared_reg();
    cfg_write(32'hFFFF_FFF3);
    chk(cfg_rd_data == 32'd3, "R2 reserved bits zero", cfg_rd_data, 3);
    for (int i = 0; i < 3; i++) cyc(2'b11, 2'b00, 16'h300 + 16'(i), 16'h400 + 16'(i));
    chk(usr_valid == 2'b00, "R5 both at threshold", usr_valid, 0);
    cyc(2'b11, 2'b00, 16'h303, 16'h403);
    chk(usr_valid == 2'b11, "R5 both above threshold", usr_valid, 3);
    for (int i = 0; i < 4; i++) cyc(2'b00, 2'b11, 0, 0);
    chk(usr_valid == 2'b00, "R5 both drained", usr_valid, 0);
  endtask

  task automatic test_thr_change();
    cfg_write(32'd8);
    for (int i = 0; i < 5; i++) cyc(2'b01, 2'b00, 16'h500 + 16'(i), 0);
    chk(usr_valid[0] == 1'b0, "R10 before change", usr_valid[0], 0);
    cfg_write(32'd2);
    cyc(2'b00, 2'b00, 0, 0);
    chk(usr_valid[0] == 1'b1, "R10 new threshold used", usr_valid[0], 1);
    for (int i = 0; i < 5; i++) cyc(2'b00, 2'b01, 0, 0);
    chk(usr_valid[0] == 1'b0, "R10 drained", usr_valid[0], 0);
  endtask

  task automatic test_overflow();
    cfg_write(32'd15);
    for (int i = 0; i < 15; i++) cyc(2'b01, 2'b00, 16'h600 + 16'(i), 0);
    chk(usr_valid[0] == 1'b0, "R4 fifteen at threshold 15", usr_valid[0], 0);
    cyc(2'b01, 2'b00, 16'h60F, 0);
    chk(usr_valid[0] == 1'b1, "R4 full crosses 15", usr_valid[0], 1);
    chk(ovf_flag == 2'b00, "R7 no overflow yet", ovf_flag, 0);
    cyc(2'b01, 2'b00, 16'hDEAD, 0);
    chk(ovf_flag == 2'b01, "R7 overflow flagged", ovf_flag, 1);
    for (int i = 0; i < 16; i++) cyc(2'b00, 2'b01, 0, 0);
    chk(usr_valid[0] == 1'b0, "R7 dropped word absent", usr_valid[0], 0);
    chk(ovf_flag == 2'b01, "R7 flag sticky", ovf_flag, 1);
  endtask

  task automatic test_same_cycle();
    cfg_write(32'd1);
    cyc(2'b10, 2'b00, 0, 16'h700);
    cyc(2'b10, 2'b00, 0, 16'h701);
    chk(usr_valid[1] == 1'b1, "R9 armed", usr_valid[1], 1);
    for (int i = 2; i < 8; i++) begin
      cyc(2'b10, 2'b10, 0, 16'h700 + 16'(i));
      chk(usr_valid[1] == 1'b1, "R9 valid kept", usr_valid[1], 1);
    end
    cyc(2'b00, 2'b10, 0, 0);
    chk(usr_valid[1] == 1'b1, "R9 one left", usr_valid[1], 1);
    cyc(2'b00, 2'b10, 0, 0);
    chk(usr_valid[1] == 1'b0, "R9 count was two", usr_valid[1], 0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_gate_default();
    test_shared_reg();
    test_thr_change();
    test_overflow();
    test_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule